// File: doc/BRIEF.md
# Height-Method Crisp Output Stage

This block is the last stage of a fuzzy controller. It takes four activation grades and the peak position of the consequent that each grade belongs to. It returns the weighted average of the peaks, using the grades as weights, as one 8-bit crisp value. Every operand is an unsigned 8-bit code on an offset scale. The real interval from -80 to +80 is stretched over codes 0 to 255, so code 0x80 is the real zero, 0x00 is -80, 0x0D is -72 and 0xF2 is +72.

A one-cycle `start` pulse, given while the block is idle, captures all eight operands. The block then forms the sum of grade-times-peak products and the sum of grades in one step. A restoring divider resolves one quotient bit per enabled cycle. A `done_o` pulse marks a fresh result. Both sums also appear on debug outputs. When every grade is zero, the block skips the division and returns the scale's zero point. A clock enable stalls the whole block, and a synchronous reset returns it to idle.

Top module: `crisp_height_defuzz`

## Requirements
- R1: On `done_o`, `crisp_o` equals the sum of grade times peak divided by the sum of grades, truncated toward zero. Examples: grades 17 and 170 on peaks 128 and 140 give 138 (0x8A). Grades 43, 128 and 128 on peaks 128, 140 and 242 give 181 (0xB5). Grades 170 and 85 on peaks 128 and 140 give 132 (0x84).
- R2: `num_o` shows the full 18-bit sum of the four products without overflow. All grades and peaks at 255 give 260100.
- R3: `den_o` shows the 10-bit sum of the four grades. Four grades of 255 give 1020.
- R4: When all four grades are zero, `crisp_o` is 0x80 and `num_o` and `den_o` are 0.
- R5: Pair m (m = 0..3) sits at bits [8m+7:8m] of `grade_i` and of `peak_i`. The operands are captured only by `start` while idle with `ce` high. Later changes to the inputs, and a `start` while busy, have no effect on the result, and a `start` while busy produces no extra `done_o`.
- R6: `busy_o` rises on the enabled edge after an accepted `start`. `done_o` is high for exactly one enabled cycle. It rises on the 20th enabled edge after the start edge is counted as the first, or on the 2nd enabled edge when all grades are zero. At that same edge `busy_o` falls.
- R7: While `ce` is low, no state advances, and `crisp_o`, `done_o`, `num_o` and `den_o` hold their values.
- R8: Synchronous active-high `rst` clears `crisp_o`, `num_o`, `den_o`, `done_o` and `busy_o` to 0, abandoning any division in progress.
- R9: When only one grade is nonzero, `crisp_o` equals that pair's peak at both ends of the scale (for example 13 or 242).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all state |
| start | input | 1 | Capture operands and begin (idle only) |
| grade_i | input | 32 | Four 8-bit activation grades, pair m at [8m+7:8m] |
| peak_i | input | 32 | Four 8-bit consequent peaks, pair m at [8m+7:8m] |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-enabled-cycle result pulse |
| crisp_o | output | 8 | Crisp weighted average |
| num_o | output | 18 | Debug: sum of grade-times-peak products |
| den_o | output | 10 | Debug: sum of grades |

## Verification
The three worked controller cases check that the quotient is truncated and not rounded, since two of them sit well above the half-way point. A pair of equal weights whose exact average is x.5 and a single active grade at each end of the scale show that the truncation and the weighting are exact. All-maximum operands check the widest numerator, and all-zero grades check the bypass of the divider. Changing the inputs after the capture, a second `start` while busy, a clock-enable stall during the division and a reset in the middle of a division tell whether the operands are captured correctly, whether the enable gates every register, and whether reset abandons the work in progress.

// File: rtl/dfz_pkg.sv
package dfz_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SUM  = 2'd1,
      ST_DIV  = 2'd2
   } dfz_state_t;

   function automatic int unsigned dfz_log2up(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/dfz_mac.sv
module dfz_mac #(
   parameter int N_PAIRS = 4,
   parameter int VAL_W   = 8,
   parameter int NUM_W   = 18,
   parameter int DEN_W   = 10
) (
   input  logic [N_PAIRS*VAL_W-1:0] grades,
   input  logic [N_PAIRS*VAL_W-1:0] peaks,
   output logic [NUM_W-1:0]         num_sum,
   output logic [DEN_W-1:0]         den_sum
);
   logic [NUM_W-1:0] prod [N_PAIRS];
   logic [DEN_W-1:0] wgt  [N_PAIRS];

   for (genvar i = 0; i < N_PAIRS; i++) begin : g_pair
      assign prod[i] = NUM_W'(grades[i*VAL_W +: VAL_W]) * NUM_W'(peaks[i*VAL_W +: VAL_W]);
      assign wgt[i]  = DEN_W'(grades[i*VAL_W +: VAL_W]);
   end

   always_comb begin
      num_sum = '0;
      den_sum = '0;
      for (int k = 0; k < N_PAIRS; k++) begin
         num_sum = num_sum + prod[k];
         den_sum = den_sum + wgt[k];
      end
   end
endmodule

// File: rtl/dfz_divider.sv
module dfz_divider #(
   parameter int NUM_W = 18,
   parameter int DEN_W = 10,
   parameter int Q_W   = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ce,
   input  logic             load,
   input  logic [NUM_W-1:0] dividend,
   input  logic [DEN_W-1:0] divisor,
   output logic             fin_o,
   output logic [Q_W-1:0]   quot_nxt_o
);
   import dfz_pkg::*;

   localparam int CW = (NUM_W > 1) ? dfz_log2up(NUM_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(NUM_W - 1);

   logic [NUM_W-1:0] quo_q;
   logic [DEN_W-1:0] rem_q;
   logic [DEN_W-1:0] dvs_q;
   logic [CW-1:0]    cnt_q;
   logic             run_q;

   logic [DEN_W:0]   shifted;
   logic [DEN_W:0]   diff;
   logic             ge;
   logic [DEN_W-1:0] rem_nxt;
   logic [NUM_W-1:0] quo_nxt;

   always_comb begin
      shifted = {rem_q, quo_q[NUM_W-1]};
      diff    = shifted - {1'b0, dvs_q};
      ge      = (shifted >= {1'b0, dvs_q});
      rem_nxt = ge ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
      quo_nxt = {quo_q[NUM_W-2:0], ge};
   end

   assign fin_o      = run_q && ce && (cnt_q == LAST);
   assign quot_nxt_o = quo_nxt[Q_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         quo_q <= '0;
         rem_q <= '0;
         dvs_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (ce) begin
         if (load) begin
            quo_q <= dividend;
            rem_q <= '0;
            dvs_q <= divisor;
            cnt_q <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            quo_q <= quo_nxt;
            rem_q <= rem_nxt;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) run_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dfz_ctrl.sv
module dfz_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic ce,
   input  logic start,
   input  logic empty_i,
   input  logic div_fin_i,
   output logic latch_o,
   output logic sum_o,
   output logic div_load_o,
   output logic empty_fin_o,
   output logic busy_o
);
   import dfz_pkg::*;

   dfz_state_t st_q, st_d;

   always_comb begin
      st_d        = st_q;
      latch_o     = 1'b0;
      sum_o       = 1'b0;
      div_load_o  = 1'b0;
      empty_fin_o = 1'b0;
      if (ce) begin
         unique case (st_q)
            ST_IDLE: if (start) begin
               latch_o = 1'b1;
               st_d    = ST_SUM;
            end
            ST_SUM: begin
               sum_o = 1'b1;
               if (empty_i) begin
                  empty_fin_o = 1'b1;
                  st_d        = ST_IDLE;
               end else begin
                  div_load_o = 1'b1;
                  st_d       = ST_DIV;
               end
            end
            ST_DIV: if (div_fin_i) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
         endcase
      end
   end

   assign busy_o = (st_q != ST_IDLE);

   always_ff @(posedge clk) begin
      if (rst) st_q <= ST_IDLE;
      else     st_q <= st_d;
   end
endmodule

// File: rtl/crisp_height_defuzz.sv
module crisp_height_defuzz #(
   parameter int               N_PAIRS   = 4,
   parameter int               VAL_W     = 8,
   parameter logic [VAL_W-1:0] ZERO_CODE = 8'h80
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         ce,
   input  logic                         start,
   input  logic [N_PAIRS*VAL_W-1:0]     grade_i,
   input  logic [N_PAIRS*VAL_W-1:0]     peak_i,
   output logic                         busy_o,
   output logic                         done_o,
   output logic [VAL_W-1:0]             crisp_o,
   output logic [2*VAL_W+dfz_pkg::dfz_log2up(N_PAIRS)-1:0] num_o,
   output logic [VAL_W+dfz_pkg::dfz_log2up(N_PAIRS)-1:0]   den_o
);
   import dfz_pkg::*;

   localparam int SUM_X = dfz_log2up(N_PAIRS);
   localparam int NUM_W = 2*VAL_W + SUM_X;
   localparam int DEN_W = VAL_W + SUM_X;

   if (N_PAIRS < 1) begin : g_bad_pairs
      $error("N_PAIRS must be at least 1");
   end
   if (VAL_W < 2) begin : g_bad_width
      $error("VAL_W must be at least 2");
   end

   logic [N_PAIRS*VAL_W-1:0] grade_q, peak_q;
   logic [NUM_W-1:0]         num_c, num_q;
   logic [DEN_W-1:0]         den_c, den_q;
   logic [VAL_W-1:0]         crisp_q;
   logic                     done_q;
   logic                     latch, sum_en, div_load, empty_fin, div_fin;
   logic [VAL_W-1:0]         quot_nxt;

   dfz_mac #(.N_PAIRS(N_PAIRS), .VAL_W(VAL_W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_mac (
      .grades  (grade_q),
      .peaks   (peak_q),
      .num_sum (num_c),
      .den_sum (den_c)
   );

   dfz_ctrl u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .ce          (ce),
      .start       (start),
      .empty_i     (den_c == '0),
      .div_fin_i   (div_fin),
      .latch_o     (latch),
      .sum_o       (sum_en),
      .div_load_o  (div_load),
      .empty_fin_o (empty_fin),
      .busy_o      (busy_o)
   );

   dfz_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(VAL_W)) u_div (
      .clk        (clk),
      .rst        (rst),
      .ce         (ce),
      .load       (div_load),
      .dividend   (num_c),
      .divisor    (den_c),
      .fin_o      (div_fin),
      .quot_nxt_o (quot_nxt)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         grade_q <= '0;
         peak_q  <= '0;
         num_q   <= '0;
         den_q   <= '0;
         crisp_q <= '0;
         done_q  <= 1'b0;
      end else if (ce) begin
         if (latch) begin
            grade_q <= grade_i;
            peak_q  <= peak_i;
         end
         if (sum_en) begin
            num_q <= num_c;
            den_q <= den_c;
         end
         if (empty_fin)    crisp_q <= ZERO_CODE;
         else if (div_fin) crisp_q <= quot_nxt;
         done_q <= empty_fin | div_fin;
      end
   end

   assign done_o  = done_q;
   assign crisp_o = crisp_q;
   assign num_o   = num_q;
   assign den_o   = den_q;
endmodule

// File: rtl/dfz_checker.sv
module dfz_checker #(
   parameter int               VAL_W     = 8,
   parameter int               NUM_W     = 18,
   parameter int               DEN_W     = 10,
   parameter logic [VAL_W-1:0] ZERO_CODE = 8'h80
) (
   input logic             clk,
   input logic             rst,
   input logic             ce,
   input logic             start,
   input logic             busy_o,
   input logic             done_o,
   input logic [VAL_W-1:0] crisp_o,
   input logic [NUM_W-1:0] num_o,
   input logic [DEN_W-1:0] den_o
);
   logic [NUM_W+1:0] lo_bound, hi_bound;
   assign lo_bound = (NUM_W+2)'(crisp_o) * (NUM_W+2)'(den_o);
   assign hi_bound = ((NUM_W+2)'(crisp_o) + 1'b1) * (NUM_W+2)'(den_o);

   // R1: the result is the truncated quotient of the shown sums
   a_r1_trunc_bound: assert property (@(posedge clk) disable iff (rst)
      (done_o && den_o != '0) |-> ((NUM_W+2)'(num_o) >= lo_bound && (NUM_W+2)'(num_o) < hi_bound));

   // R4: an all-zero weight set yields the zero point
   a_r4_empty_zero: assert property (@(posedge clk) disable iff (rst)
      (done_o && den_o == '0) |-> (crisp_o == ZERO_CODE && num_o == '0));

   // R6: an accepted start makes the block busy
   a_r6_busy_rise: assert property (@(posedge clk) disable iff (rst)
      (ce && start && !busy_o) |=> busy_o);

   // R6: done lasts one enabled cycle and is never seen with busy
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
      (done_o && ce) |=> !done_o);
   a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
      done_o |-> !busy_o);

   // R7: a disabled cycle freezes every output
   a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
      !ce |=> ($stable(crisp_o) && $stable(done_o) && $stable(num_o) && $stable(den_o) && $stable(busy_o)));

   // R8: reset clears outputs
   a_r8_reset_clear: assert property (@(posedge clk)
      $past(rst) |-> (!done_o && !busy_o && crisp_o == '0 && num_o == '0 && den_o == '0));
endmodule

bind crisp_height_defuzz dfz_checker #(
   .VAL_W(VAL_W), .NUM_W(NUM_W), .DEN_W(DEN_W), .ZERO_CODE(ZERO_CODE)
) u_dfz_chk (
   .clk(clk), .rst(rst), .ce(ce), .start(start), .busy_o(busy_o), .done_o(done_o),
   .crisp_o(crisp_o), .num_o(num_o), .den_o(den_o)
);

// File: tb/crisp_height_defuzz_bench.sv
`timescale 1ns/1ps
module crisp_height_defuzz_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ce  = 1'b1;
   logic        start = 1'b0;
   logic [31:0] grade_i = '0;
   logic [31:0] peak_i  = '0;
   logic        busy_o, done_o;
   logic [7:0]  crisp_o;
   logic [17:0] num_o;
   logic [9:0]  den_o;

   always #2.5 clk = ~clk;

   crisp_height_defuzz u_crisp_height_defuzz (
      .clk(clk), .rst(rst), .ce(ce), .start(start), .grade_i(grade_i), .peak_i(peak_i),
      .busy_o(busy_o), .done_o(done_o), .crisp_o(crisp_o), .num_o(num_o), .den_o(den_o)
   );

   typedef struct {
      int    crisp;
      int    num;
      int    den;
      int    lat;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_run  = 0;
   int   n_fail = 0;
   int   lat_cnt = 0;
   bit   seen = 0;
   bit   finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, expv);
      end
   endtask

   // counts enabled edges since the accepted start (start edge = 1)
   always @(posedge clk) begin
      if (rst) lat_cnt <= 0;
      else if (ce) begin
         if (start && !busy_o) lat_cnt <= 1;
         else if (busy_o)      lat_cnt <= lat_cnt + 1;
      end
   end

   // monitor: compare each new result with the scoreboard head
   always @(negedge clk) begin
      if (!rst) begin
         if (done_o && !seen) begin
            seen <= 1'b1;
            if (exp_q.size() == 0) chk(1'b0, "R5 unexpected done", 1, 0);
            else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(crisp_o == e.crisp, {e.tag, " crisp"}, crisp_o, e.crisp);
               chk(num_o == e.num, "R2 numerator", num_o, e.num);
               chk(den_o == e.den, "R3 denominator", den_o, e.den);
               chk(lat_cnt == e.lat, "R6 latency", lat_cnt, e.lat);
               chk(!busy_o, "R6 busy low at done", busy_o, 0);
            end
         end
         if (!done_o) seen <= 1'b0;
      end
   end

   task automatic send(input logic [7:0] g0, g1, g2, g3, p0, p1, p2, p3, input string tag);
      exp_t e;
      while (busy_o || done_o) @(negedge clk);
      e.num = g0*p0 + g1*p1 + g2*p2 + g3*p3;
      e.den = g0 + g1 + g2 + g3;
      e.crisp = (e.den == 0) ? 128 : e.num / e.den;
      e.lat = (e.den == 0) ? 2 : 20;
      e.tag = tag;
      exp_q.push_back(e);
      grade_i = {g3, g2, g1, g0};
      peak_i  = {p3, p2, p1, p0};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      grade_i = 32'h5A3C_F00F;  // R5: post-capture changes must not matter
      peak_i  = 32'hC3A5_1E77;
   endtask

   task automatic drain();
      for (int i = 0; i < 200 && (exp_q.size() != 0 || busy_o); i++) @(negedge clk);
      chk(exp_q.size() == 0, "R6 result arrived", exp_q.size(), 0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(5.0 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] hold;
      int unsigned s;
      repeat (3) @(negedge clk);
      chk(crisp_o == 0 && num_o == 0 && den_o == 0, "R8 reset outputs", crisp_o, 0);
      chk(!done_o && !busy_o, "R8 reset flags", {done_o, busy_o}, 0);
      rst = 1'b0;
      @(negedge clk);

      send(8'd17, 8'd170, 8'd0, 8'd0, 8'd128, 8'd140, 8'd13, 8'd242, "R1 case 138");
      send(8'd43, 8'd128, 8'd128, 8'd0, 8'd128, 8'd140, 8'd242, 8'd115, "R1 case 181");
      send(8'd170, 8'd85, 8'd0, 8'd0, 8'd128, 8'd140, 8'd115, 8'd13, "R1 case 132");
      send(8'd1, 8'd1, 8'd0, 8'd0, 8'd115, 8'd140, 8'd128, 8'd128, "R1 half truncates");
      send(8'd0, 8'd0, 8'd200, 8'd0, 8'd115, 8'd140, 8'd13, 8'd128, "R9 single at 13");
      send(8'd0, 8'd0, 8'd0, 8'd9, 8'd115, 8'd140, 8'd13, 8'd242, "R9 single at 242");
      send(8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 8'd255, "R2 max operands");
      send(8'd0, 8'd0, 8'd0, 8'd0, 8'd13, 8'd115, 8'd140, 8'd242, "R4 empty weights");
      drain();

      s = 32'h1234_5678;
      for (int t = 0; t < 6; t++) begin
         logic [7:0] r [8];
         for (int k = 0; k < 8; k++) begin
            s = s * 1664525 + 1013904223;
            r[k] = s[23:16];
         end
         send(r[0], r[1], r[2], r[3], r[4], r[5], r[6], r[7], "R1 mixed");
      end
      drain();

      // R5: start while busy is ignored
      send(8'd40, 8'd90, 8'd0, 8'd0, 8'd115, 8'd242, 8'd0, 8'd0, "R5 busy start");
      repeat (4) @(negedge clk);
      grade_i = 32'h0000_00FF; peak_i = 32'h0000_000D; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      drain();
      repeat (25) @(negedge clk);
      chk(!done_o && !busy_o, "R5 no extra run", {done_o, busy_o}, 0);

      // R7: stall mid-division
      send(8'd60, 8'd30, 8'd10, 8'd0, 8'd13, 8'd128, 8'd242, 8'd0, "R7 stalled run");
      repeat (6) @(negedge clk);
      ce = 1'b0;
      hold = crisp_o;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         chk(crisp_o == hold && !done_o && busy_o, "R7 hold while ce low", crisp_o, hold);
      end
      ce = 1'b1;
      drain();

      // R8: reset abandons a division
      send(8'd50, 8'd50, 8'd0, 8'd0, 8'd115, 8'd140, 8'd0, 8'd0, "R8 aborted");
      repeat (5) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      exp_q.delete();
      rst = 1'b0;
      chk(crisp_o == 0 && num_o == 0 && den_o == 0 && !busy_o, "R8 mid-run reset", crisp_o, 0);
      for (int i = 0; i < 25; i++) begin
         @(negedge clk);
         if (done_o) chk(1'b0, "R8 no done after reset", 1, 0);
      end
      chk(!busy_o, "R8 idle after reset", busy_o, 0);

      send(8'd100, 8'd0, 8'd0, 8'd50, 8'd13, 8'd0, 8'd0, 8'd242, "R1 after reset");
      drain();

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule